// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block forms the memory address of an operand from an addressing-mode code, four 16-bit pointer registers (two base pointers and two index pointers), a short or long displacement and three segment registers. It first builds a 16-bit offset from the terms the mode calls for. It then picks a segment: the stack segment when the stack base pointer is part of the address, and the data segment otherwise. A valid override input can replace that choice. The physical address is the segment shifted left by four bits plus the offset.

An instruction-execution pipeline uses it between operand decode and the bus unit. A parameter selects one of two variants. In the registered variant, the default, all results are captured on the rising edge that samples the inputs and held until the next edge. In the other variant the outputs follow the inputs combinationally. Widths, the segment shift and the short-displacement width are parameters, and they are checked at elaboration.

Top module: `seg_addr_gen`

## Requirements
- R1: Mode code 0 (direct) gives an offset equal to the displacement alone, extended as in R6.
- R2: Mode code 1 (pointer indirect) gives an offset equal to one pointer, chosen by `ind_sel_i`: 0 = base pointer BX, 1 = stack base BP, 2 = index SI, 3 = index DI.
- R3: Mode code 2 (based) gives an offset of base + displacement, with the base chosen by `base_sel_i`: 0 = BX, 1 = BP.
- R4: Mode code 3 (indexed) gives an offset of index + displacement, with the index chosen by `idx_sel_i`: 0 = SI, 1 = DI. A negative displacement subtracts; for example, data segment 0200h, DI 0030h and a long displacement of FFF8h give 02028h.
- R5: Mode code 4 (based-indexed) gives base + index, and the displacement has no effect. Mode code 5 gives base + index + displacement; for example, data segment 0300h, BX 1000h, DI 0010h and 2080h give 06090h.
- R6: With `disp_long_i` = 0, only `disp_i[7:0]` is used, sign-extended to 16 bits, and `disp_i[15:8]` has no effect. With `disp_long_i` = 1, all 16 bits are used.
- R7: Without an override, the segment code `seg_sel_o` is 1 (stack, `ss_i`) when BP takes part in the address (mode 1 with selector 1, or modes 2, 4 and 5 with `base_sel_i` = 1). In every other case it is 0 (data, `ds_i`). For example, stack segment 2000h, BP 4000h and SI 0800h in mode 4 give 24800h.
- R8: When `ovr_valid_i` = 1, the segment code becomes `ovr_seg_i` (0 = data, 1 = stack, 2 = extra, `es_i`). Code 3 is treated as data. `seg_o` is then the register that the code names.
- R9: The offset wraps modulo 2^16, and `phys_o` = (segment × 16 + offset) modulo 2^20.
- R10: In the registered variant, the outputs change only on a rising clock edge and reflect the inputs sampled at that edge. While `rst_n` is low, all outputs are zero.
- R11: Mode codes 6 and 7 behave as direct mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the output stage |
| mode_i | input | 3 | Addressing-mode code |
| base_sel_i | input | 1 | Base select: 0 BX, 1 BP |
| idx_sel_i | input | 1 | Index select: 0 SI, 1 DI |
| ind_sel_i | input | 2 | Pointer select for indirect mode |
| disp_i | input | 16 | Displacement |
| disp_long_i | input | 1 | 1: use the 16-bit displacement; 0: sign-extend the low byte |
| bx_i | input | 16 | Base pointer BX |
| bp_i | input | 16 | Stack base pointer BP |
| si_i | input | 16 | Index pointer SI |
| di_i | input | 16 | Index pointer DI |
| ds_i | input | 16 | Data segment |
| ss_i | input | 16 | Stack segment |
| es_i | input | 16 | Extra segment |
| ovr_valid_i | input | 1 | Segment override valid |
| ovr_seg_i | input | 2 | Override segment code |
| offset_o | output | 16 | Computed offset |
| seg_sel_o | output | 2 | Chosen segment code |
| seg_o | output | 16 | Chosen segment value |
| phys_o | output | 20 | Physical address |

## Verification
In the default registered variant, every result (offset, segment code, segment value and physical address) is due on the first rising edge after the inputs are set up, and none is due earlier. The bench changes inputs on a falling edge and compares all four outputs on the next falling edge, so exactly one rising edge lies between stimulus and sample. One scenario also samples shortly after a change of inputs and before the next rising edge, and expects the previous address to still be present.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
   typedef enum logic [2:0] {
      AM_DIRECT    = 3'd0,
      AM_INDIRECT  = 3'd1,
      AM_BASED     = 3'd2,
      AM_INDEXED   = 3'd3,
      AM_BIDX      = 3'd4,
      AM_BIDX_DISP = 3'd5,
      AM_RSV6      = 3'd6,
      AM_RSV7      = 3'd7
   } amode_e;

   typedef enum logic [1:0] {
      SEG_DATA  = 2'd0,
      SEG_STACK = 2'd1,
      SEG_EXTRA = 2'd2,
      SEG_RSV   = 2'd3
   } segsel_e;

   typedef enum logic [1:0] {
      PTR_BX = 2'd0,
      PTR_BP = 2'd1,
      PTR_SI = 2'd2,
      PTR_DI = 2'd3
   } ptrsel_e;
endpackage

// File: rtl/seg_offset_calc.sv
module seg_offset_calc
   import seg_addr_pkg::*;
#(
   parameter int OFS_W    = 16,
   parameter int DSHORT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  amode_e           mode,
   input  logic             base_sel,
   input  logic             idx_sel,
   input  ptrsel_e          ind_sel,
   input  logic [OFS_W-1:0] disp,
   input  logic             disp_long,
   input  logic [OFS_W-1:0] bx,
   input  logic [OFS_W-1:0] bp,
   input  logic [OFS_W-1:0] si,
   input  logic [OFS_W-1:0] di,
   output logic [OFS_W-1:0] ofs,
   output logic             uses_bp
);
   localparam int EXT_W = OFS_W - DSHORT_W;

   generate
      if (DSHORT_W < 2 || DSHORT_W >= OFS_W) begin : g_bad_dshort
         $error("seg_offset_calc: DSHORT_W must lie in 2..OFS_W-1");
      end
   endgenerate

   logic [OFS_W-1:0] disp_ext;
   logic [OFS_W-1:0] base_val;
   logic [OFS_W-1:0] idx_val;
   logic [OFS_W-1:0] ptr_val;
   logic [OFS_W-1:0] term_a;
   logic [OFS_W-1:0] term_b;
   logic [OFS_W-1:0] term_d;

   always_comb begin
      if (disp_long) disp_ext = disp;
      else           disp_ext = {{EXT_W{disp[DSHORT_W-1]}}, disp[DSHORT_W-1:0]};
   end

   assign base_val = base_sel ? bp : bx;
   assign idx_val  = idx_sel  ? di : si;

   always_comb begin
      case (ind_sel)
         PTR_BX:  ptr_val = bx;
         PTR_BP:  ptr_val = bp;
         PTR_SI:  ptr_val = si;
         default: ptr_val = di;
      endcase
   end

   always_comb begin
      term_a  = '0;
      term_b  = '0;
      term_d  = disp_ext;
      uses_bp = 1'b0;
      case (mode)
         AM_INDIRECT: begin
            term_a  = ptr_val;
            term_d  = '0;
            uses_bp = (ind_sel == PTR_BP);
         end
         AM_BASED: begin
            term_a  = base_val;
            uses_bp = base_sel;
         end
         AM_INDEXED: begin
            term_a = idx_val;
         end
         AM_BIDX: begin
            term_a  = base_val;
            term_b  = idx_val;
            term_d  = '0;
            uses_bp = base_sel;
         end
         AM_BIDX_DISP: begin
            term_a  = base_val;
            term_b  = idx_val;
            uses_bp = base_sel;
         end
         default: begin
            term_a = '0;
         end
      endcase
   end

   assign ofs = term_a + term_b + term_d;

   // R2: indirect through SI yields SI unchanged
   a_r2_indirect_si: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == AM_INDIRECT && ind_sel == PTR_SI) |-> (ofs == si));

   // R6: a short direct displacement fills the upper bits with its sign
   a_r6_short_sign: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == AM_DIRECT && !disp_long) |->
         (ofs[OFS_W-1:DSHORT_W] == {EXT_W{disp[DSHORT_W-1]}}));

   // R5: based-indexed without displacement ignores disp
   a_r5_no_disp: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == AM_BIDX && $stable(bx) && $stable(bp) && $stable(si) && $stable(di)
       && $stable(base_sel) && $stable(idx_sel) && $past(mode) == AM_BIDX)
      |-> $stable(ofs));
endmodule

// File: rtl/seg_select.sv
module seg_select
   import seg_addr_pkg::*;
#(
   parameter int SEG_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             uses_bp,
   input  logic             ovr_valid,
   input  segsel_e          ovr_code,
   input  logic [SEG_W-1:0] ds,
   input  logic [SEG_W-1:0] ss,
   input  logic [SEG_W-1:0] es,
   output segsel_e          sel,
   output logic [SEG_W-1:0] seg
);
   generate
      if (SEG_W < 1) begin : g_bad_seg
         $error("seg_select: SEG_W must be positive");
      end
   endgenerate

   segsel_e dflt_code;
   segsel_e ovr_clean;

   assign dflt_code = uses_bp ? SEG_STACK : SEG_DATA;
   assign ovr_clean = (ovr_code == SEG_RSV) ? SEG_DATA : ovr_code;
   assign sel       = ovr_valid ? ovr_clean : dflt_code;

   always_comb begin
      case (sel)
         SEG_STACK: seg = ss;
         SEG_EXTRA: seg = es;
         default:   seg = ds;
      endcase
   end

   // R7: stack base in the address picks the stack segment
   a_r7_bp_stack: assert property (@(posedge clk) disable iff (!rst_n)
      (!ovr_valid && uses_bp) |-> (sel == SEG_STACK && seg == ss));

   // R8: an extra-segment override delivers the extra segment
   a_r8_ovr_extra: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_valid && ovr_code == SEG_EXTRA) |-> (seg == es));
endmodule

// File: rtl/seg_phys_combine.sv
module seg_phys_combine #(
   parameter int SEG_W  = 16,
   parameter int OFS_W  = 16,
   parameter int SHIFT  = 4,
   parameter int PHYS_W = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SEG_W-1:0]  seg,
   input  logic [OFS_W-1:0]  ofs,
   output logic [PHYS_W-1:0] phys
);
   generate
      if (SHIFT < 1 || PHYS_W < OFS_W || PHYS_W <= SHIFT) begin : g_bad_geom
         $error("seg_phys_combine: need SHIFT>=1, PHYS_W>=OFS_W, PHYS_W>SHIFT");
      end
   endgenerate

   logic [PHYS_W-1:0] seg_pos;
   logic [PHYS_W-1:0] ofs_pos;

   assign seg_pos = PHYS_W'(seg) << SHIFT;
   assign ofs_pos = PHYS_W'(ofs);
   assign phys    = seg_pos + ofs_pos;

   // R9: the low bits below the segment shift come straight from the offset
   a_r9_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
      phys[SHIFT-1:0] == ofs[SHIFT-1:0]);
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
   import seg_addr_pkg::*;
#(
   parameter int OFS_W      = 16,
   parameter int SEG_W      = 16,
   parameter int DSHORT_W   = 8,
   parameter int SEG_SHIFT  = 4,
   parameter int PHYS_W     = 20,
   parameter bit REGISTERED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        mode_i,
   input  logic              base_sel_i,
   input  logic              idx_sel_i,
   input  logic [1:0]        ind_sel_i,
   input  logic [OFS_W-1:0]  disp_i,
   input  logic              disp_long_i,
   input  logic [OFS_W-1:0]  bx_i,
   input  logic [OFS_W-1:0]  bp_i,
   input  logic [OFS_W-1:0]  si_i,
   input  logic [OFS_W-1:0]  di_i,
   input  logic [SEG_W-1:0]  ds_i,
   input  logic [SEG_W-1:0]  ss_i,
   input  logic [SEG_W-1:0]  es_i,
   input  logic              ovr_valid_i,
   input  logic [1:0]        ovr_seg_i,
   output logic [OFS_W-1:0]  offset_o,
   output logic [1:0]        seg_sel_o,
   output logic [SEG_W-1:0]  seg_o,
   output logic [PHYS_W-1:0] phys_o
);
   logic [OFS_W-1:0]  ofs_c;
   logic              uses_bp_c;
   segsel_e           sel_c;
   logic [SEG_W-1:0]  seg_c;
   logic [PHYS_W-1:0] phys_c;

   seg_offset_calc #(.OFS_W(OFS_W), .DSHORT_W(DSHORT_W)) u_ofs (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (amode_e'(mode_i)),
      .base_sel  (base_sel_i),
      .idx_sel   (idx_sel_i),
      .ind_sel   (ptrsel_e'(ind_sel_i)),
      .disp      (disp_i),
      .disp_long (disp_long_i),
      .bx        (bx_i),
      .bp        (bp_i),
      .si        (si_i),
      .di        (di_i),
      .ofs       (ofs_c),
      .uses_bp   (uses_bp_c)
   );

   seg_select #(.SEG_W(SEG_W)) u_sel (
      .clk       (clk),
      .rst_n     (rst_n),
      .uses_bp   (uses_bp_c),
      .ovr_valid (ovr_valid_i),
      .ovr_code  (segsel_e'(ovr_seg_i)),
      .ds        (ds_i),
      .ss        (ss_i),
      .es        (es_i),
      .sel       (sel_c),
      .seg       (seg_c)
   );

   seg_phys_combine #(.SEG_W(SEG_W), .OFS_W(OFS_W), .SHIFT(SEG_SHIFT),
                      .PHYS_W(PHYS_W)) u_phys (
      .clk   (clk),
      .rst_n (rst_n),
      .seg   (seg_c),
      .ofs   (ofs_c),
      .phys  (phys_c)
   );

   generate
      if (REGISTERED) begin : g_reg
         logic primed;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               offset_o  <= '0;
               seg_sel_o <= '0;
               seg_o     <= '0;
               phys_o    <= '0;
               primed    <= 1'b0;
            end else begin
               offset_o  <= ofs_c;
               seg_sel_o <= sel_c;
               seg_o     <= seg_c;
               phys_o    <= phys_c;
               primed    <= 1'b1;
            end
         end

         // R10: a steady address keeps the registered address steady
         a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (primed && $stable(phys_c)) |=> $stable(phys_o));
      end else begin : g_comb
         assign offset_o  = ofs_c;
         assign seg_sel_o = sel_c;
         assign seg_o     = seg_c;
         assign phys_o    = phys_c;
      end
   endgenerate
endmodule

// File: tb/test_seg_addr_gen.sv
`timescale 1ns/100ps
module test_seg_addr_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  mode_i = 3'd0;
   logic        base_sel_i = 1'b0;
   logic        idx_sel_i = 1'b0;
   logic [1:0]  ind_sel_i = 2'd0;
   logic [15:0] disp_i = 16'h1111;
   logic        disp_long_i = 1'b1;
   logic [15:0] bx_i = 16'h2222, bp_i = 16'h3333, si_i = 16'h4444, di_i = 16'h5555;
   logic [15:0] ds_i = 16'h6666, ss_i = 16'h7777, es_i = 16'h8888;
   logic        ovr_valid_i = 1'b0;
   logic [1:0]  ovr_seg_i = 2'd0;
   logic [15:0] offset_o;
   logic [1:0]  seg_sel_o;
   logic [15:0] seg_o;
   logic [19:0] phys_o;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   seg_addr_gen i_seg_addr_gen (
      .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .base_sel_i(base_sel_i),
      .idx_sel_i(idx_sel_i), .ind_sel_i(ind_sel_i), .disp_i(disp_i),
      .disp_long_i(disp_long_i), .bx_i(bx_i), .bp_i(bp_i), .si_i(si_i),
      .di_i(di_i), .ds_i(ds_i), .ss_i(ss_i), .es_i(es_i),
      .ovr_valid_i(ovr_valid_i), .ovr_seg_i(ovr_seg_i), .offset_o(offset_o),
      .seg_sel_o(seg_sel_o), .seg_o(seg_o), .phys_o(phys_o)
   );

   task automatic chk(string req, logic [15:0] e_ofs, logic [1:0] e_sel,
                      logic [15:0] e_seg, logic [19:0] e_phys);
      n_vec++;
      if (offset_o !== e_ofs || seg_sel_o !== e_sel || seg_o !== e_seg
          || phys_o !== e_phys) begin
         n_bad++;
         $display("FAIL %s: ofs=%h sel=%0d seg=%h phys=%h expected ofs=%h sel=%0d seg=%h phys=%h",
                  req, offset_o, seg_sel_o, seg_o, phys_o, e_ofs, e_sel, e_seg, e_phys);
      end
   endtask

   task automatic settle();
      @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      chk("R10 reset", 16'h0, 2'd0, 16'h0, 20'h0);
      rst_n = 1'b1;
   endtask

   task automatic t_direct();
      @(negedge clk);
      mode_i = 3'd0; ds_i = 16'h1000; disp_i = 16'h7000; disp_long_i = 1'b1;
      ovr_valid_i = 1'b0;
      settle();
      chk("R1 direct long", 16'h7000, 2'd0, 16'h1000, 20'h17000);
      disp_i = 16'h12F0; disp_long_i = 1'b0;
      settle();
      chk("R6 short negative", 16'hFFF0, 2'd0, 16'h1000, 20'h1FFF0);
      disp_i = 16'hAB05;
      settle();
      chk("R6 upper bits ignored", 16'h0005, 2'd0, 16'h1000, 20'h10005);
   endtask

   task automatic t_indirect();
      @(negedge clk);
      mode_i = 3'd1; ind_sel_i = 2'd2; ds_i = 16'h0800; si_i = 16'h2000;
      disp_i = 16'h0055; disp_long_i = 1'b1;
      settle();
      chk("R2 indirect SI", 16'h2000, 2'd0, 16'h0800, 20'h0A000);
      ind_sel_i = 2'd1; ss_i = 16'h0800; bp_i = 16'h2000;
      settle();
      chk("R7 indirect BP stack", 16'h2000, 2'd1, 16'h0800, 20'h0A000);
      ind_sel_i = 2'd3; di_i = 16'h0123;
      settle();
      chk("R2 indirect DI", 16'h0123, 2'd0, 16'h0800, 20'h08123);
   endtask

   task automatic t_based();
      @(negedge clk);
      mode_i = 3'd2; base_sel_i = 1'b0; ds_i = 16'h0100; bx_i = 16'h0600;
      disp_i = 16'h0004; disp_long_i = 1'b0;
      settle();
      chk("R3 based BX", 16'h0604, 2'd0, 16'h0100, 20'h01604);
      base_sel_i = 1'b1; ss_i = 16'h0A00; bp_i = 16'h0012; disp_i = 16'h00F9;
      settle();
      chk("R3 R7 based BP minus 7", 16'h000B, 2'd1, 16'h0A00, 20'h0A00B);
   endtask

   task automatic t_indexed();
      @(negedge clk);
      mode_i = 3'd3; idx_sel_i = 1'b1; ds_i = 16'h0200; di_i = 16'h0030;
      disp_i = 16'hFFF8; disp_long_i = 1'b1; base_sel_i = 1'b1;
      settle();
      chk("R4 indexed DI minus 8", 16'h0028, 2'd0, 16'h0200, 20'h02028);
   endtask

   task automatic t_bidx();
      @(negedge clk);
      mode_i = 3'd4; base_sel_i = 1'b1; idx_sel_i = 1'b0; ss_i = 16'h2000;
      bp_i = 16'h4000; si_i = 16'h0800; disp_i = 16'h1234; disp_long_i = 1'b1;
      settle();
      chk("R5 R7 bidx BP SI", 16'h4800, 2'd1, 16'h2000, 20'h24800);
      mode_i = 3'd5; base_sel_i = 1'b0; idx_sel_i = 1'b1; ds_i = 16'h0300;
      bx_i = 16'h1000; di_i = 16'h0010; disp_i = 16'h2080;
      settle();
      chk("R5 bidx disp", 16'h3090, 2'd0, 16'h0300, 20'h06090);
   endtask

   task automatic t_wrap();
      @(negedge clk);
      mode_i = 3'd4; base_sel_i = 1'b0; idx_sel_i = 1'b0; ds_i = 16'hF000;
      bx_i = 16'hFFFF; si_i = 16'h0002;
      settle();
      chk("R9 offset wrap", 16'h0001, 2'd0, 16'hF000, 20'hF0001);
      mode_i = 3'd0; ds_i = 16'hFFFF; disp_i = 16'h0020; disp_long_i = 1'b1;
      settle();
      chk("R9 address wrap", 16'h0020, 2'd0, 16'hFFFF, 20'h00010);
   endtask

   task automatic t_override();
      @(negedge clk);
      mode_i = 3'd4; base_sel_i = 1'b1; idx_sel_i = 1'b0; ss_i = 16'h2000;
      bp_i = 16'h4000; si_i = 16'h0800; es_i = 16'h3000; ds_i = 16'h0500;
      ovr_valid_i = 1'b1; ovr_seg_i = 2'd2;
      settle();
      chk("R8 override extra", 16'h4800, 2'd2, 16'h3000, 20'h34800);
      ovr_seg_i = 2'd0;
      settle();
      chk("R8 override data on BP", 16'h4800, 2'd0, 16'h0500, 20'h09800);
      ovr_seg_i = 2'd3;
      settle();
      chk("R8 code 3 as data", 16'h4800, 2'd0, 16'h0500, 20'h09800);
      base_sel_i = 1'b0; bx_i = 16'h0100; ovr_seg_i = 2'd1;
      settle();
      chk("R8 override stack on BX", 16'h0900, 2'd1, 16'h2000, 20'h20900);
      ovr_valid_i = 1'b0;
   endtask

   task automatic t_reserved();
      @(negedge clk);
      mode_i = 3'd6; ds_i = 16'h0040; disp_i = 16'h0017; disp_long_i = 1'b1;
      bx_i = 16'h9999; si_i = 16'h9999;
      settle();
      chk("R11 mode 6 direct", 16'h0017, 2'd0, 16'h0040, 20'h00417);
      mode_i = 3'd7;
      settle();
      chk("R11 mode 7 direct", 16'h0017, 2'd0, 16'h0040, 20'h00417);
   endtask

   task automatic t_hold();
      @(negedge clk);
      mode_i = 3'd0; ds_i = 16'h1000; disp_i = 16'h0100; disp_long_i = 1'b1;
      settle();
      chk("R10 settled", 16'h0100, 2'd0, 16'h1000, 20'h10100);
      disp_i = 16'h0200;
      #1;
      chk("R10 no change before edge", 16'h0100, 2'd0, 16'h1000, 20'h10100);
      settle();
      chk("R10 update after edge", 16'h0200, 2'd0, 16'h1000, 20'h10200);
   endtask

   initial begin
      #100000;
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
   end

   initial begin
      t_reset();
      t_direct();
      t_indirect();
      t_based();
      t_indexed();
      t_bidx();
      t_wrap();
      t_override();
      t_reserved();
      t_hold();
      finish_run();
   end
endmodule